// File: doc/BRIEF.md
# Double-Sampled Route Error Detector

This block sits beside the virtual-channel allocator of a network-on-chip input port. It checks every route result that the route logic produces for a packet header. The route vector is an output port plus a virtual network. It is observed twice. A shadow register captures it on the falling clock edge in the middle of the route cycle, and the main register captures it on the rising edge that ends that cycle. Neither capture lengthens the route path.

In the next cycle the detector compares the two samples. It tests each sample for legality against the header's destination and the router's own coordinates. It also takes two legality flags from the allocator: one for the main request and one for the alternate sample. From these it picks exactly one outcome per header: accept the main sample, fall back to the shadow sample, or ask for a reroute. The outcome is a one-cycle pulse tagged with the virtual-channel index of the header, and it appears two clock edges after the header was presented.

A fault-injection mask on the shadow path lets a test force the two samples apart, so that every branch of the decision can be reached.

Top module: `dsamp_route_guard`

## Requirements
- R1: While reset is held, and in the cycles that follow until a header has been checked, `dec_accept`, `dec_retry`, `dec_reroute` and `req_valid` are 0.
- R2: A header presented with `hdr_valid` high in cycle N produces exactly one of `dec_accept`, `dec_retry`, `dec_reroute` in cycle N+2, carrying that header's `hdr_vc` on `dec_vc`. No pulse appears in a cycle whose cycle N-2 had no header.
- R3: The shadow sample is `{hdr_port, hdr_vn}` XOR `shadow_flip`. A nonzero mask makes the samples differ. When the main sample passes, it is accepted anyway.
- R4: Port codes are 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y, 5 up (+Z), 6 down (-Z), 7 unused. A local choice is legal only when all three destination coordinates equal the current ones.
- R5: An up choice is illegal unless the destination Z exceeds the current Z. A down choice is illegal unless the destination Z is below the current Z.
- R6: A positive choice (codes 1, 3, 5) is illegal while any destination coordinate is below the current one. Code 7 is always illegal.
- R7: When `va_err_main` is 0 and the main sample is legal, `dec_accept` pulses and `dec_port`/`dec_vn` carry the main sample.
- R8: When the samples match and the main sample fails, whether through `va_err_main` or through illegality, `dec_reroute` pulses. In that case `va_err_alt` and the shadow legality have no effect on the outcome.
- R9: When the samples differ, the main sample fails, the shadow sample is legal and `va_err_alt` is 0, `dec_retry` pulses and `dec_port`/`dec_vn` carry the shadow sample.
- R10: When the samples differ, the main sample fails, and either the shadow sample is illegal or `va_err_alt` is 1, `dec_reroute` pulses.
- R11: In cycle N+1 `req_valid` is 1. `req_port`/`req_vn` show the main sample and `alt_port`/`alt_vn` show the shadow sample. `va_err_main` and `va_err_alt` are sampled in this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; main capture on rising edge, shadow on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hdr_valid | input | 1 | A route result is present this cycle |
| hdr_vc | input | VCW | Virtual-channel index of the header |
| hdr_port | input | 3 | Output port chosen by route logic |
| hdr_vn | input | VNW | Virtual network chosen by route logic |
| cur_x | input | CW | Router X coordinate |
| cur_y | input | CW | Router Y coordinate |
| cur_z | input | CW | Router Z coordinate |
| dst_x | input | CW | Destination X |
| dst_y | input | CW | Destination Y |
| dst_z | input | CW | Destination Z |
| shadow_flip | input | 3+VNW | Fault-injection XOR mask on the shadow sample |
| va_err_main | input | 1 | Allocator legality error on the main request (check cycle) |
| va_err_alt | input | 1 | Allocator legality error on the shadow sample (check cycle) |
| req_valid | output | 1 | Check cycle active |
| req_port | output | 3 | Main sample port |
| req_vn | output | VNW | Main sample virtual network |
| alt_port | output | 3 | Shadow sample port |
| alt_vn | output | VNW | Shadow sample virtual network |
| dec_accept | output | 1 | Pulse: main sample accepted |
| dec_retry | output | 1 | Pulse: shadow sample used |
| dec_reroute | output | 1 | Pulse: reroute requested |
| dec_vc | output | VCW | Virtual channel of the decided header |
| dec_port | output | 3 | Port of the chosen sample |
| dec_vn | output | VNW | Virtual network of the chosen sample |

## Verification
The busiest cycle has two jobs at once. The detector judges one header from its registered samples and the allocator flags, while it captures the next header on both clock edges. Headers are therefore driven back to back, both in directed runs and in random runs where most cycles carry a header. Each outcome is compared against a model that sees the header two cycles earlier and its allocator flags one cycle earlier. A mix-up between the checked header and the header being captured shows up as a wrong tag, sample or decision. The shadow fault mask and an allocator error are also placed on the same header, so that sample disagreement and allocator failure have to be resolved in one decision.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int PW = 3;

  typedef enum logic [PW-1:0] {
    P_LOCAL = 3'd0,
    P_XPOS  = 3'd1,
    P_XNEG  = 3'd2,
    P_YPOS  = 3'd3,
    P_YNEG  = 3'd4,
    P_UP    = 3'd5,
    P_DOWN  = 3'd6,
    P_NONE  = 3'd7
  } port_e;
endpackage

// File: rtl/dsr_sampler.sv
module dsr_sampler #(
  parameter int RW  = 5,
  parameter int AW  = 18,
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           in_valid,
  input  logic [RW-1:0]  in_route,
  input  logic [RW-1:0]  in_flip,
  input  logic [VCW-1:0] in_vc,
  input  logic [AW-1:0]  in_loc,
  output logic           s_valid,
  output logic [RW-1:0]  s_main,
  output logic [RW-1:0]  s_shadow,
  output logic [VCW-1:0] s_vc,
  output logic [AW-1:0]  s_loc
);
  logic [RW-1:0] shadow_q;

  // mid-cycle observation of the route result
  always_ff @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (in_valid) begin
      shadow_q <= in_route ^ in_flip;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s_valid <= 1'b0;
    end else begin
      s_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s_main   <= '0;
      s_shadow <= '0;
      s_vc     <= '0;
      s_loc    <= '0;
    end else if (in_valid) begin
      s_main   <= in_route;
      s_shadow <= shadow_q;
      s_vc     <= in_vc;
      s_loc    <= in_loc;
    end
  end
endmodule

// File: rtl/dsr_legality.sv
module dsr_legality #(
  parameter int CW = 3
) (
  input  logic [2:0]    port,
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [CW-1:0] cz,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW-1:0] dz,
  output logic          illegal
);
  import dsr_pkg::*;

  logic neg_left;
  logic arrived;

  always_comb begin
    neg_left = (dx < cx) || (dy < cy) || (dz < cz);
    arrived  = (dx == cx) && (dy == cy) && (dz == cz);
    unique case (port_e'(port))
      P_LOCAL: illegal = !arrived;
      P_XPOS:  illegal = neg_left;
      P_XNEG:  illegal = 1'b0;
      P_YPOS:  illegal = neg_left;
      P_YNEG:  illegal = 1'b0;
      P_UP:    illegal = !(dz > cz) || neg_left;
      P_DOWN:  illegal = !(dz < cz);
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsr_decide.sv
module dsr_decide #(
  parameter int RW  = 5,
  parameter int VCW = 2
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           chk_valid,
  input  logic [RW-1:0]  smp_main,
  input  logic [RW-1:0]  smp_shadow,
  input  logic [VCW-1:0] chk_vc,
  input  logic           bad_main,
  input  logic           bad_shadow,
  input  logic           aerr_main,
  input  logic           aerr_alt,
  output logic           o_accept,
  output logic           o_retry,
  output logic           o_reroute,
  output logic [RW-1:0]  o_route,
  output logic [VCW-1:0] o_vc
);
  logic          nx_accept, nx_retry, nx_reroute;
  logic [RW-1:0] nx_route;
  logic          same, main_fail;

  always_comb begin
    same       = (smp_main == smp_shadow);
    main_fail  = aerr_main || bad_main;
    nx_accept  = 1'b0;
    nx_retry   = 1'b0;
    nx_reroute = 1'b0;
    if (chk_valid) begin
      if (!main_fail) begin
        nx_accept = 1'b1;
      end else if (same) begin
        nx_reroute = 1'b1;
      end else if (bad_shadow || aerr_alt) begin
        nx_reroute = 1'b1;
      end else begin
        nx_retry = 1'b1;
      end
    end
    nx_route = nx_retry ? smp_shadow : smp_main;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      o_accept  <= 1'b0;
      o_retry   <= 1'b0;
      o_reroute <= 1'b0;
    end else begin
      o_accept  <= nx_accept;
      o_retry   <= nx_retry;
      o_reroute <= nx_reroute;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      o_route <= '0;
      o_vc    <= '0;
    end else if (chk_valid) begin
      o_route <= nx_route;
      o_vc    <= chk_vc;
    end
  end
endmodule

// File: rtl/dsamp_route_guard.sv
module dsamp_route_guard #(
  parameter int CW  = 3,
  parameter int VNW = 2,
  parameter int VCW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  input  logic [VCW-1:0]       hdr_vc,
  input  logic [2:0]           hdr_port,
  input  logic [VNW-1:0]       hdr_vn,
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  input  logic [CW-1:0]        cur_z,
  input  logic [CW-1:0]        dst_x,
  input  logic [CW-1:0]        dst_y,
  input  logic [CW-1:0]        dst_z,
  input  logic [2+VNW:0]       shadow_flip,
  input  logic                 va_err_main,
  input  logic                 va_err_alt,
  output logic                 req_valid,
  output logic [2:0]           req_port,
  output logic [VNW-1:0]       req_vn,
  output logic [2:0]           alt_port,
  output logic [VNW-1:0]       alt_vn,
  output logic                 dec_accept,
  output logic                 dec_retry,
  output logic                 dec_reroute,
  output logic [VCW-1:0]       dec_vc,
  output logic [2:0]           dec_port,
  output logic [VNW-1:0]       dec_vn
);
  import dsr_pkg::*;

  localparam int RW = PW + VNW;
  localparam int AW = 6 * CW;

  logic [1:0]    rst_pipe;
  logic          rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  logic           s_valid;
  logic [RW-1:0]  s_main, s_shadow, dec_route;
  logic [VCW-1:0] s_vc;
  logic [AW-1:0]  s_loc;

  dsr_sampler #(.RW(RW), .AW(AW), .VCW(VCW)) u_smp (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .in_valid (hdr_valid),
    .in_route ({hdr_port, hdr_vn}),
    .in_flip  (shadow_flip),
    .in_vc    (hdr_vc),
    .in_loc   ({cur_x, cur_y, cur_z, dst_x, dst_y, dst_z}),
    .s_valid  (s_valid),
    .s_main   (s_main),
    .s_shadow (s_shadow),
    .s_vc     (s_vc),
    .s_loc    (s_loc)
  );

  logic [RW-1:0] smp  [2];
  logic          bad  [2];

  assign smp[0] = s_main;
  assign smp[1] = s_shadow;

  for (genvar g = 0; g < 2; g++) begin : g_leg
    dsr_legality #(.CW(CW)) u_leg (
      .port    (smp[g][RW-1:VNW]),
      .cx      (s_loc[6*CW-1:5*CW]),
      .cy      (s_loc[5*CW-1:4*CW]),
      .cz      (s_loc[4*CW-1:3*CW]),
      .dx      (s_loc[3*CW-1:2*CW]),
      .dy      (s_loc[2*CW-1:CW]),
      .dz      (s_loc[CW-1:0]),
      .illegal (bad[g])
    );
  end

  dsr_decide #(.RW(RW), .VCW(VCW)) u_dec (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .chk_valid  (s_valid),
    .smp_main   (s_main),
    .smp_shadow (s_shadow),
    .chk_vc     (s_vc),
    .bad_main   (bad[0]),
    .bad_shadow (bad[1]),
    .aerr_main  (va_err_main),
    .aerr_alt   (va_err_alt),
    .o_accept   (dec_accept),
    .o_retry    (dec_retry),
    .o_reroute  (dec_reroute),
    .o_route    (dec_route),
    .o_vc       (dec_vc)
  );

  assign req_valid = s_valid;
  assign req_port  = s_main[RW-1:VNW];
  assign req_vn    = s_main[VNW-1:0];
  assign alt_port  = s_shadow[RW-1:VNW];
  assign alt_vn    = s_shadow[VNW-1:0];
  assign dec_port  = dec_route[RW-1:VNW];
  assign dec_vn    = dec_route[VNW-1:0];
endmodule

// File: rtl/dsamp_route_guard_chk.sv
module dsamp_route_guard_chk #(
  parameter int CW  = 3,
  parameter int VNW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [2:0]     req_port,
  input logic [VNW-1:0] req_vn,
  input logic [2:0]     alt_port,
  input logic [VNW-1:0] alt_vn,
  input logic           va_err_main,
  input logic           va_err_alt,
  input logic           dec_accept,
  input logic           dec_retry,
  input logic           dec_reroute,
  input logic [2:0]     dec_port,
  input logic [VNW-1:0] dec_vn,
  input logic [CW-1:0]  cur_z,
  input logic [CW-1:0]  dst_z
);
  logic any_dec;
  assign any_dec = dec_accept | dec_retry | dec_reroute;

  assert_one_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_accept, dec_retry, dec_reroute}));

  assert_decision_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> any_dec);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !any_dec);

  assert_accept_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> ({dec_port, dec_vn} == $past({req_port, req_vn})) && !$past(va_err_main));

  assert_retry_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_retry |-> ({dec_port, dec_vn} == $past({alt_port, alt_vn}))
                  && ($past({req_port, req_vn}) != $past({alt_port, alt_vn}))
                  && !$past(va_err_alt));

  assert_match_err_reroute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && va_err_main && ({req_port, req_vn} == {alt_port, alt_vn})) |=> dec_reroute);

  assert_up_needs_higher_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_accept && dec_port == 3'd5) |-> ($past(dst_z, 2) > $past(cur_z, 2)));
endmodule

bind dsamp_route_guard dsamp_route_guard_chk #(.CW(CW), .VNW(VNW)) u_chk (.*);

// File: tb/sim_dsamp_route_guard.sv
module sim_dsamp_route_guard;
  localparam int CW  = 3;
  localparam int VNW = 2;
  localparam int VCW = 2;
  localparam int FW  = 3 + VNW;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           hdr_valid;
  logic [VCW-1:0] hdr_vc;
  logic [2:0]     hdr_port;
  logic [VNW-1:0] hdr_vn;
  logic [CW-1:0]  cur_x, cur_y, cur_z, dst_x, dst_y, dst_z;
  logic [FW-1:0]  shadow_flip;
  logic           va_err_main, va_err_alt;
  logic           req_valid;
  logic [2:0]     req_port, alt_port, dec_port;
  logic [VNW-1:0] req_vn, alt_vn, dec_vn;
  logic           dec_accept, dec_retry, dec_reroute;
  logic [VCW-1:0] dec_vc;

  always #5 clk = ~clk;

  dsamp_route_guard #(.CW(CW), .VNW(VNW), .VCW(VCW)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;

  // header one step back (in check cycle)
  bit         p1_v = 0;
  bit [FW-1:0] p1_route, p1_flip;
  bit [VCW-1:0] p1_vc;
  int         p1_c[3], p1_d[3];
  bit         p1_a1, p1_a2;
  string      p1_tag;
  // header two steps back (decision visible)
  bit         p2_v = 0;
  bit [2:0]   p2_kind;
  bit [FW-1:0] p2_route;
  bit [VCW-1:0] p2_vc;
  string      p2_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit illegal_fn(input bit [2:0] p, input int c[3], input int d[3]);
    bit neg = (d[0] < c[0]) || (d[1] < c[1]) || (d[2] < c[2]);
    case (p)
      3'd0: return !(d[0] == c[0] && d[1] == c[1] && d[2] == c[2]);
      3'd1, 3'd3: return neg;
      3'd2, 3'd4: return 1'b0;
      3'd5: return !(d[2] > c[2]) || neg;
      3'd6: return !(d[2] < c[2]);
      default: return 1'b1;
    endcase
  endfunction

  // kind bits: {accept, retry, reroute}
  function automatic bit [2:0] kind_fn(input bit [FW-1:0] r, input bit [FW-1:0] f,
                                       input int c[3], input int d[3],
                                       input bit a1, input bit a2);
    bit [FW-1:0] r2 = r ^ f;
    if (!(a1 || illegal_fn(r[FW-1:VNW], c, d))) return 3'b100;
    if (f == '0) return 3'b001;
    if (illegal_fn(r2[FW-1:VNW], c, d) || a2) return 3'b001;
    return 3'b010;
  endfunction

  task automatic step(input bit v, input bit [2:0] port, input bit [VNW-1:0] vn,
                      input bit [FW-1:0] flip, input bit [VCW-1:0] vc,
                      input int cx, input int cy, input int cz,
                      input int dx, input int dy, input int dz,
                      input bit a1, input bit a2, input string tag);
    bit [2:0] act;
    @(posedge clk); #1;
    act = {dec_accept, dec_retry, dec_reroute};
    if (p2_v) begin
      check(act == p2_kind, p2_tag, "decision {acc,retry,rr}", act, p2_kind);
      check({dec_port, dec_vn} == p2_route, p2_tag, "chosen sample", {dec_port, dec_vn}, p2_route);
      check(dec_vc == p2_vc, "R2", "vc tag", dec_vc, p2_vc);
    end else begin
      check(act == 3'b000, "R2", "no decision without header", act, 0);
    end
    if (p1_v) begin
      check(req_valid && {req_port, req_vn} == p1_route, "R11", "main sample",
            {req_port, req_vn}, p1_route);
      check({alt_port, alt_vn} == (p1_route ^ p1_flip), "R11", "shadow sample",
            {alt_port, alt_vn}, p1_route ^ p1_flip);
    end else begin
      check(!req_valid, "R11", "req_valid idle", req_valid, 0);
    end
    va_err_main = p1_a1;
    va_err_alt  = p1_a2;
    p2_v = p1_v;
    if (p1_v) begin
      p2_kind  = kind_fn(p1_route, p1_flip, p1_c, p1_d, p1_a1, p1_a2);
      p2_route = (p2_kind == 3'b010) ? (p1_route ^ p1_flip) : p1_route;
      p2_vc    = p1_vc;
      p2_tag   = p1_tag;
    end
    p1_v = v; p1_route = {port, vn}; p1_flip = flip; p1_vc = vc;
    p1_c[0] = cx; p1_c[1] = cy; p1_c[2] = cz;
    p1_d[0] = dx; p1_d[1] = dy; p1_d[2] = dz;
    p1_a1 = a1; p1_a2 = a2; p1_tag = tag;
    hdr_valid = v; hdr_port = port; hdr_vn = vn; shadow_flip = flip; hdr_vc = vc;
    cur_x = CW'(cx); cur_y = CW'(cy); cur_z = CW'(cz);
    dst_x = CW'(dx); dst_y = CW'(dy); dst_z = CW'(dz);
  endtask

  task automatic idle();
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hdr_valid = 0; hdr_vc = 0; hdr_port = 0; hdr_vn = 0;
    cur_x = 0; cur_y = 0; cur_z = 0; dst_x = 0; dst_y = 0; dst_z = 0;
    shadow_flip = 0; va_err_main = 0; va_err_alt = 0;
    repeat (3) @(posedge clk);
    #1;
    check({dec_accept, dec_retry, dec_reroute, req_valid} == 4'b0, "R1", "outputs in reset",
          {dec_accept, dec_retry, dec_reroute, req_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check({dec_accept, dec_retry, dec_reroute, req_valid} == 4'b0, "R1", "outputs after release",
          {dec_accept, dec_retry, dec_reroute, req_valid}, 0);

    // directed, back to back
    step(1, 3'd1, 2'd1, 0, 2'd0, 1,1,1, 3,3,1, 0,0, "R7");
    step(1, 3'd0, 2'd0, 0, 2'd1, 2,2,2, 2,2,2, 0,0, "R4");
    step(1, 3'd0, 2'd0, 0, 2'd2, 2,2,2, 2,3,2, 0,0, "R4");
    step(1, 3'd5, 2'd2, 0, 2'd3, 1,1,1, 1,2,3, 0,0, "R5");
    step(1, 3'd5, 2'd2, 0, 2'd0, 1,1,2, 1,1,1, 0,0, "R5");
    step(1, 3'd6, 2'd0, 0, 2'd1, 1,1,1, 1,1,3, 0,0, "R5");
    step(1, 3'd6, 2'd0, 0, 2'd2, 1,1,3, 1,1,1, 0,0, "R5");
    step(1, 3'd3, 2'd0, 0, 2'd3, 2,1,1, 1,3,1, 0,0, "R6");
    step(1, 3'd7, 2'd0, 0, 2'd0, 1,1,1, 2,2,2, 0,0, "R6");
    step(1, 3'd2, 2'd1, 0, 2'd1, 3,1,1, 1,3,1, 0,0, "R6");
    step(1, 3'd1, 2'd0, 0, 2'd2, 1,1,1, 3,1,1, 1,0, "R8");
    step(1, 3'd1, 2'd0, 0, 2'd3, 1,1,1, 3,1,1, 1,1, "R8");
    step(1, 3'd1, 2'd0, 5'b01100, 2'd0, 3,1,1, 1,2,1, 0,0, "R9");
    step(1, 3'd1, 2'd0, 5'b01100, 2'd1, 1,1,1, 3,2,1, 0,0, "R3");
    step(1, 3'd1, 2'd0, 5'b01000, 2'd2, 3,1,1, 1,2,1, 0,0, "R10");
    step(1, 3'd1, 2'd0, 5'b01100, 2'd3, 3,1,1, 1,2,1, 0,1, "R10");
    step(1, 3'd1, 2'd2, 5'b00001, 2'd0, 1,1,1, 3,1,1, 1,0, "R9");
    step(1, 3'd2, 2'd2, 5'b00001, 2'd1, 1,1,1, 3,1,1, 1,0, "R6");
    idle(); idle(); idle();

    void'($urandom(32'd1234));
    for (int i = 0; i < 800; i++) begin
      bit [FW-1:0] f = ($urandom % 3 == 0) ? FW'($urandom) : '0;
      step(($urandom % 4) != 0, 3'($urandom), VNW'($urandom), f, VCW'($urandom),
           $urandom % 4, $urandom % 4, $urandom % 4,
           $urandom % 4, $urandom % 4, $urandom % 4,
           ($urandom % 5) == 0, ($urandom % 3) == 0, "R2");
    end
    idle(); idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule